// File: doc/BRIEF.md
# Stopwatch Tick Interrupt Flag Unit

This block turns three periodic stopwatch ticks into interrupt requests. The ticks run at about 100 Hz, 10 Hz and 1 Hz. Each tick is a level signal in the system clock domain. When a tick goes from 1 to 0, the block latches a per-source flag, but only if software has turned that source on. A source that is off never records its edge. Its enable bit therefore gates the flag itself, not only the request that comes out of it.

The three flags drive one shared request line to an external interrupt controller. The handler reads the flag register to find which tick fired. It then clears that bit by writing a 1 to it. Both registers sit on a small synchronous bus with one-cycle read latency. The enable register is at the base address and the flag register is one 32-bit word above it.

Top module: `tick_irq_unit`

## Requirements
- R1: After reset, the enable register, the flag register, `irq_o` and `bus_rdata` are all 0.
- R2: An enabled tick that reads 1 and then 0 on two consecutive clocks sets its flag at the second clock edge. A rising edge, or a level held high or low, sets nothing.
- R3: Bit 0 belongs to the 100 Hz tick, bit 1 to the 10 Hz tick and bit 2 to the 1 Hz tick. The same positions apply in the enable register and in the flag register.
- R4: While a source's enable bit is 0, a falling edge on its tick leaves its flag at 0 and raises no request.
- R5: `irq_o` is 1 exactly when at least one flag is 1, and it changes at the same edge as the flags.
- R6: A flag stays at 1 until a bus write to the flag register carries a 1 in that bit position. Writing 0 to a flag bit leaves it unchanged.
- R7: If a falling edge sets a flag in the same cycle that a write clears the same bit, the flag ends up at 1.
- R8: Turning an enable bit off does not clear a flag that is already set, and `irq_o` stays at 1 until that flag is cleared.
- R9: The enable register is at byte address 0 and the flag register at byte address 4.
  - A read (`bus_sel`=1, `bus_wr`=0) returns the register in bits 2:0 of `bus_rdata` on the next cycle, with the upper bits 0.
  - Any other address reads as 0, and writes to it change nothing.
  - `bus_rdata` is 0 in every cycle that follows a cycle without a read.
- R10: A write to the enable register applies to falling edges from the following cycle on. An edge in the same cycle as the write uses the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 3 | Tick levels: bit 0 is 100 Hz, bit 1 is 10 Hz, bit 2 is 1 Hz |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Shared interrupt request |

## Verification
Some internal faults show up on `irq_o` at the very next edge: a lost edge sample, a stale enable or a flag that fails to hold. Among them, a falling edge that should have set a flag leaves `irq_o` low one clock too long. A flag that is wrong while another flag already holds `irq_o` high is invisible on that pin. It only appears when the flag register is read, one cycle after the read strobe. The bench therefore compares `irq_o` and `bus_rdata` against a behavioural model on every clock. It also reads both registers after each scenario.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  // Register decoded by the current bus address.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_MASK = 2'd1,
    ACC_FLAG = 2'd2
  } acc_sel_e;
endpackage

// File: rtl/tick_fall_det.sv
module tick_fall_det #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic [NUM_SRC-1:0] fall_o
);
  logic [NUM_SRC-1:0] prev_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) prev_q[k] <= 1'b0;
      else     prev_q[k] <= tick_i[k];
    end
    // Edge seen when the stored sample is 1 and the live level is 0.
    assign fall_o[k] = prev_q[k] & ~tick_i[k];
  end
endmodule

// File: rtl/tick_flag_bank.sv
module tick_flag_bank #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic [NUM_SRC-1:0] clr,
  input  logic [NUM_SRC-1:0] fall,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] flag_q,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] flag_d;

  // Set takes priority over clear.
  assign flag_d = (fall & en_q) | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      flag_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      flag_q <= flag_d;
      irq_o  <= |flag_d;
    end
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q[k]) |-> $past(fall[k] & en_q[k])); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag_q[k] && !clr[k]) |=> flag_q[k]); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (fall[k] && en_q[k] && clr[k]) |=> flag_q[k]); // R7
  end
endmodule

// File: rtl/tick_reg_if.sv
module tick_reg_if
  import tick_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MASK_ADDR = 0,
  parameter int unsigned FLAG_ADDR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] flag_q,
  output logic               en_wr,
  output logic [NUM_SRC-1:0] en_wdata,
  output logic [NUM_SRC-1:0] clr,
  output logic [DATA_W-1:0]  rdata_o
);
  acc_sel_e acc;
  logic     wr_hit_flag;
  logic     unused_wdata_hi;

  always_comb begin
    acc = ACC_NONE;
    if (bus_addr == ADDR_W'(MASK_ADDR))      acc = ACC_MASK;
    else if (bus_addr == ADDR_W'(FLAG_ADDR)) acc = ACC_FLAG;
  end

  assign en_wr           = bus_sel & bus_wr & (acc == ACC_MASK);
  assign en_wdata        = bus_wdata[NUM_SRC-1:0];
  assign wr_hit_flag     = bus_sel & bus_wr & (acc == ACC_FLAG);
  assign clr             = {NUM_SRC{wr_hit_flag}} & bus_wdata[NUM_SRC-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (acc)
        ACC_MASK: rdata_o <= DATA_W'(en_q);
        ACC_FLAG: rdata_o <= DATA_W'(flag_q);
        default:  rdata_o <= '0;
      endcase
    end else begin
      rdata_o <= '0;
    end
  end

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata_o[DATA_W-1:NUM_SRC] == '0); // R9
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> rdata_o == '0); // R9
endmodule

// File: rtl/tick_irq_unit.sv
module tick_irq_unit #(
  parameter int unsigned NUM_SRC   = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MASK_ADDR = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  localparam int unsigned FLAG_ADDR = MASK_ADDR + DATA_W / 8;

  logic [NUM_SRC-1:0] fall;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] en_wdata;
  logic [NUM_SRC-1:0] clr;
  logic               en_wr;

  tick_fall_det #(.NUM_SRC(NUM_SRC)) u_det (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .fall_o (fall)
  );

  tick_reg_if #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MASK_ADDR (MASK_ADDR),
    .FLAG_ADDR (FLAG_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .clr       (clr),
    .rdata_o   (bus_rdata)
  );

  tick_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .clr      (clr),
    .fall     (fall),
    .en_q     (en_q),
    .flag_q   (flag_q),
    .irq_o    (irq_o)
  );

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|flag_q)); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !bus_sel) |=> irq_o); // R8
endmodule

// File: tb/tb_tick_irq_unit.sv
module tb_tick_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  tick_i = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural model state
  bit [2:0]  m_en, m_flag, m_prev;
  bit        m_irq;
  bit [31:0] m_rdata;

  tick_irq_unit dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 0; m_flag <= 0; m_prev <= 0; m_irq <= 0; m_rdata <= 0;
    end else begin
      bit [2:0] nf;
      nf = m_flag;
      for (int k = 0; k < 3; k++) begin
        bit clear_k, set_k;
        clear_k = bus_sel && bus_wr && bus_addr == 8'd4 && bus_wdata[k];
        set_k   = m_prev[k] && !tick_i[k] && m_en[k];
        if (clear_k) nf[k] = 0;
        if (set_k)   nf[k] = 1;
      end
      if (bus_sel && !bus_wr)
        m_rdata <= (bus_addr == 8'd0) ? {29'd0, m_en} :
                   (bus_addr == 8'd4) ? {29'd0, m_flag} : 32'd0;
      else
        m_rdata <= 0;
      if (bus_sel && bus_wr && bus_addr == 8'd0) m_en <= bus_wdata[2:0];
      m_flag <= nf;
      m_irq  <= |nf;
      m_prev <= tick_i;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5 model irq", {31'd0, irq_o}, {31'd0, m_irq});
      chk("R9 model rdata", bus_rdata, m_rdata);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic set_tick(input logic [2:0] v);
    @(negedge clk);
    tick_i = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R1 rdata after reset", bus_rdata, 32'd0);
    read_chk(8'd0, 32'd0, "R1 enable reset");
    read_chk(8'd4, 32'd0, "R1 flag reset");

    // R4: disabled source ignores its edge
    set_tick(3'b001); set_tick(3'b000); set_tick(3'b000);
    read_chk(8'd4, 32'd0, "R4 disabled edge no flag");
    chk("R4 no irq", {31'd0, irq_o}, 32'd0);

    bus_write(8'd0, 32'hFFFF_FFFF);
    read_chk(8'd0, 32'd7, "R9 enable readback upper zero");

    // R2: rising edge and steady high do nothing
    set_tick(3'b010); repeat (3) set_tick(3'b010);
    read_chk(8'd4, 32'd0, "R2 rising edge no flag");
    set_tick(3'b000);
    @(negedge clk);
    chk("R5 irq after fall", {31'd0, irq_o}, 32'd1);
    read_chk(8'd4, 32'd2, "R2 R3 10Hz fall sets bit1");

    // R6: write 0 keeps, write 1 clears
    bus_write(8'd4, 32'd0);
    read_chk(8'd4, 32'd2, "R6 write0 keeps flag");
    bus_write(8'd4, 32'd2);
    read_chk(8'd4, 32'd0, "R6 write1 clears flag");
    chk("R5 irq low after clear", {31'd0, irq_o}, 32'd0);

    // R3: bit positions
    set_tick(3'b100); set_tick(3'b000);
    read_chk(8'd4, 32'd4, "R3 1Hz is bit2");
    set_tick(3'b001); set_tick(3'b000);
    read_chk(8'd4, 32'd5, "R3 100Hz is bit0");
    bus_write(8'd4, 32'd7);
    read_chk(8'd4, 32'd0, "R6 clear all");

    // R7: set wins over clear
    set_tick(3'b001); set_tick(3'b000);
    set_tick(3'b001);
    @(negedge clk);
    tick_i = 3'b000; bus_sel = 1; bus_wr = 1; bus_addr = 8'd4; bus_wdata = 32'd1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    read_chk(8'd4, 32'd1, "R7 set wins");

    // R8: disable keeps set flag
    bus_write(8'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 irq held after disable", {31'd0, irq_o}, 32'd1);
    read_chk(8'd4, 32'd1, "R8 flag kept after disable");
    bus_write(8'd4, 32'd1);
    @(negedge clk);
    chk("R8 irq drops on clear", {31'd0, irq_o}, 32'd0);

    // R10: edge in same cycle as enable write uses old enable
    set_tick(3'b010);
    @(negedge clk);
    tick_i = 3'b000; bus_sel = 1; bus_wr = 1; bus_addr = 8'd0; bus_wdata = 32'd2;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    read_chk(8'd4, 32'd0, "R10 old enable applied");
    set_tick(3'b010); set_tick(3'b000);
    read_chk(8'd4, 32'd2, "R10 new enable applied");

    // R9: unmapped address
    bus_write(8'd8, 32'd7);
    read_chk(8'd8, 32'd0, "R9 unmapped reads zero");
    read_chk(8'd0, 32'd2, "R9 unmapped write ignored");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule